// File: doc/BRIEF.md
# Timer Capture/Compare Flag Controller

This block holds the status flags and raises the interrupt requests of a multifunction timer. It receives one-cycle strobes from the timer's capture, compare and counter-wrap logic. Each strobe sets a sticky flag in an 8-bit register that software can read and write. A capture strobe also copies the live counter value into one of two capture registers. The counter, the comparators and the mode logic that make these strobes sit outside the block.

Software clears a flag by writing 0 to its bit. Writing 1 to a capture flag starts a simulated capture. Two overrun flags record that a capture-0 or compare-0 event came again before its flag was cleared. One software-owned bit chooses how the two capture flags combine into the capture interrupt. All three interrupt outputs are registered levels gated by a global enable and by per-source enables.

Top module: `tcf_flag_ctrl`

## Requirements
- R1: After reset, `flags_q` reads 00h, both capture registers read 0, and all three interrupt outputs are 0.
- R2: A strobe sets its flag at the next clock edge. The flag bits are capture-0 at bit 7, capture-1 at bit 6, compare-0 at bit 5, compare-1 at bit 4 and overflow/underflow at bit 3. A capture-0 strobe loads `cnt_val` into `cap0_q` at the same edge, and a capture-1 strobe loads it into `cap1_q`.
- R3: A write (`wr_en`=1) with a 0 in any bit clears that bit. A 1 in bits 5 to 1 leaves those bits unchanged. Bit 0, the combine select, takes the written value.
- R4: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R5: A write with bit 7 = 1 loads `cnt_val` into `cap0_q` and sets bit 7 and the capture-0 overrun flag (bit 2) at the next edge.
- R6: A write with bit 6 = 1 while `bicap_mode`=0 loads `cnt_val` into `cap1_q` and sets bit 6. While `bicap_mode`=1 the same write changes neither `cap1_q` nor bit 6.
- R7: A capture-0 strobe while bit 7 is already set also sets bit 2. A compare-0 strobe while bit 5 is already set also sets bit 1. A strobe that finds its flag clear sets no overrun flag.
- R8: `irq_cap` is 1 one edge after `gie`, `ie_cap` and the capture condition all hold. The condition is bit 7 OR bit 6 when bit 0 = 0, and bit 7 AND bit 6 when bit 0 = 1.
- R9: `irq_cmp` is 1 one edge after `gie` holds together with (`ie_cmp0` and bit 5) or (`ie_cmp1` and bit 4). `irq_ovf` is 1 one edge after `gie`, `ie_ovf` and bit 3 all hold. None of the interrupts is asserted while `gie`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_cap0 | input | 1 | Capture-0 event strobe |
| ev_cap1 | input | 1 | Capture-1 event strobe |
| ev_cmp0 | input | 1 | Compare-0 event strobe |
| ev_cmp1 | input | 1 | Compare-1 event strobe |
| ev_ovf | input | 1 | Counter overflow/underflow strobe |
| cnt_val | input | 16 | Live counter value |
| bicap_mode | input | 1 | Bicapture mode active |
| gie | input | 1 | Global interrupt enable |
| ie_cap | input | 1 | Capture interrupt enable |
| ie_cmp0 | input | 1 | Compare-0 interrupt enable |
| ie_cmp1 | input | 1 | Compare-1 interrupt enable |
| ie_ovf | input | 1 | Overflow interrupt enable |
| wr_en | input | 1 | Software write strobe for the flag register |
| wr_data | input | 8 | Software write data |
| flags_q | output | 8 | Flag register |
| cap0_q | output | 16 | Capture register 0 |
| cap1_q | output | 16 | Capture register 1 |
| irq_cap | output | 1 | Capture interrupt |
| irq_cmp | output | 1 | Compare interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a hardware event strobe and a software write that clears the same flag. The second pair is a simulated capture, which sets the capture-0 overrun flag, and a clear of that overrun bit carried by the same write. The bench provokes both by applying the strobe and the write in one vector. It judges them by reading the flag register one edge later and expecting the set to win. It also repeats capture-0 and compare-0 strobes back to back, and checks that the overrun flags set only on the second strobe.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
    localparam int FLAG_W  = 8;
    localparam int BIT_CP0 = 7;
    localparam int BIT_CP1 = 6;
    localparam int BIT_CM0 = 5;
    localparam int BIT_CM1 = 4;
    localparam int BIT_OUF = 3;
    localparam int BIT_OC0 = 2;
    localparam int BIT_OM0 = 1;
    localparam int BIT_SEL = 0;
endpackage

// File: rtl/tcf_flag_bank.sv
module tcf_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                q_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                q_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tcf_cap_reg.sv
module tcf_cap_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/tcf_irq_gen.sv
module tcf_irq_gen
    import tcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              gie,
    input  logic              ie_cap,
    input  logic              ie_cmp0,
    input  logic              ie_cmp1,
    input  logic              ie_ovf,
    output logic              irq_cap,
    output logic              irq_cmp,
    output logic              irq_ovf
);
    logic cap_cond;
    logic cap_nx;
    logic cmp_nx;
    logic ovf_nx;

    always_comb begin
        if (flags_i[BIT_SEL]) begin
            cap_cond = flags_i[BIT_CP0] & flags_i[BIT_CP1];
        end else begin
            cap_cond = flags_i[BIT_CP0] | flags_i[BIT_CP1];
        end
        cap_nx = gie & ie_cap & cap_cond;
        cmp_nx = gie & ((ie_cmp0 & flags_i[BIT_CM0]) | (ie_cmp1 & flags_i[BIT_CM1]));
        ovf_nx = gie & ie_ovf & flags_i[BIT_OUF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_cap <= 1'b0;
            irq_cmp <= 1'b0;
            irq_ovf <= 1'b0;
        end else begin
            irq_cap <= cap_nx;
            irq_cmp <= cmp_nx;
            irq_ovf <= ovf_nx;
        end
    end
endmodule

// File: rtl/tcf_flag_ctrl.sv
module tcf_flag_ctrl
    import tcf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_cap0,
    input  logic              ev_cap1,
    input  logic              ev_cmp0,
    input  logic              ev_cmp1,
    input  logic              ev_ovf,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              bicap_mode,
    input  logic              gie,
    input  logic              ie_cap,
    input  logic              ie_cmp0,
    input  logic              ie_cmp1,
    input  logic              ie_ovf,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags_q,
    output logic [CNT_W-1:0]  cap0_q,
    output logic [CNT_W-1:0]  cap1_q,
    output logic              irq_cap,
    output logic              irq_cmp,
    output logic              irq_ovf
);
    localparam int NCAP = 2;

    logic [FLAG_W-1:0] set_v;
    logic [FLAG_W-1:0] clr_v;
    logic              sim0;
    logic              sim1;
    logic [NCAP-1:0]   cap_load;
    logic [CNT_W-1:0]  cap_q [NCAP];

    always_comb begin
        sim0 = wr_en & wr_data[BIT_CP0];
        sim1 = wr_en & wr_data[BIT_CP1] & ~bicap_mode;
        clr_v = {FLAG_W{wr_en}} & ~wr_data;
        set_v = '0;
        set_v[BIT_CP0] = ev_cap0 | sim0;
        set_v[BIT_CP1] = ev_cap1 | sim1;
        set_v[BIT_CM0] = ev_cmp0;
        set_v[BIT_CM1] = ev_cmp1;
        set_v[BIT_OUF] = ev_ovf;
        set_v[BIT_OC0] = (ev_cap0 & flags_q[BIT_CP0]) | sim0;
        set_v[BIT_OM0] = ev_cmp0 & flags_q[BIT_CM0];
        set_v[BIT_SEL] = wr_en & wr_data[BIT_SEL];
        cap_load[0] = ev_cap0 | sim0;
        cap_load[1] = ev_cap1 | sim1;
    end

    tcf_flag_bank #(.W(FLAG_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .q_o   (flags_q)
    );

    for (genvar c = 0; c < NCAP; c++) begin : g_cap
        tcf_cap_reg #(.W(CNT_W)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (cap_load[c]),
            .d_i    (cnt_val),
            .q_o    (cap_q[c])
        );
    end

    assign cap0_q = cap_q[0];
    assign cap1_q = cap_q[1];

    tcf_irq_gen u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_q),
        .gie     (gie),
        .ie_cap  (ie_cap),
        .ie_cmp0 (ie_cmp0),
        .ie_cmp1 (ie_cmp1),
        .ie_ovf  (ie_ovf),
        .irq_cap (irq_cap),
        .irq_cmp (irq_cmp),
        .irq_ovf (irq_ovf)
    );
endmodule

// File: rtl/tcf_flag_chk.sv
module tcf_flag_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_cap0,
    input logic             ev_cap1,
    input logic             ev_cmp0,
    input logic             ev_ovf,
    input logic [CNT_W-1:0] cnt_val,
    input logic             bicap_mode,
    input logic             gie,
    input logic             ie_ovf,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic [7:0]       flags_q,
    input logic [CNT_W-1:0] cap0_q,
    input logic [CNT_W-1:0] cap1_q,
    input logic             irq_cap,
    input logic             irq_cmp,
    input logic             irq_ovf
);
    // R2
    cap0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cap0 |=> (flags_q[7] && cap0_q == $past(cnt_val)));

    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ovf && wr_en && !wr_data[3]) |=> flags_q[3]);

    // R3
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[5] && !ev_cmp0) |=> !flags_q[5]);

    // R5
    sim_cap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7]) |=> (flags_q[7] && flags_q[2] && cap0_q == $past(cnt_val)));

    // R6
    bicap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[6] && bicap_mode && !ev_cap1) |=> $stable(cap1_q));

    // R7
    cap_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cap0 && flags_q[7]) |=> flags_q[2]);

    // R7
    cmp_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cmp0 && flags_q[5]) |=> flags_q[1]);

    // R9
    ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && ie_ovf && flags_q[3]) |=> irq_ovf);

    // R9
    gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> (!irq_cap && !irq_cmp && !irq_ovf));
endmodule

bind tcf_flag_ctrl tcf_flag_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_cap0    (ev_cap0),
    .ev_cap1    (ev_cap1),
    .ev_cmp0    (ev_cmp0),
    .ev_ovf     (ev_ovf),
    .cnt_val    (cnt_val),
    .bicap_mode (bicap_mode),
    .gie        (gie),
    .ie_ovf     (ie_ovf),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .flags_q    (flags_q),
    .cap0_q     (cap0_q),
    .cap1_q     (cap1_q),
    .irq_cap    (irq_cap),
    .irq_cmp    (irq_cmp),
    .irq_ovf    (irq_ovf)
);

// File: tb/test_tcf_flag_ctrl.sv
module test_tcf_flag_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_cap0 = 0, ev_cap1 = 0, ev_cmp0 = 0, ev_cmp1 = 0, ev_ovf = 0;
    logic [15:0] cnt_val = '0;
    logic        bicap_mode = 0, gie = 0, ie_cap = 0, ie_cmp0 = 0, ie_cmp1 = 0, ie_ovf = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  flags_q;
    logic [15:0] cap0_q, cap1_q;
    logic        irq_cap, irq_cmp, irq_ovf;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tcf_flag_ctrl i_tcf_flag_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_cap0(ev_cap0), .ev_cap1(ev_cap1), .ev_cmp0(ev_cmp0), .ev_cmp1(ev_cmp1), .ev_ovf(ev_ovf),
        .cnt_val(cnt_val), .bicap_mode(bicap_mode), .gie(gie), .ie_cap(ie_cap),
        .ie_cmp0(ie_cmp0), .ie_cmp1(ie_cmp1), .ie_ovf(ie_ovf),
        .wr_en(wr_en), .wr_data(wr_data), .flags_q(flags_q), .cap0_q(cap0_q), .cap1_q(cap1_q),
        .irq_cap(irq_cap), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    // {ev cap0,cap1,cmp0,cmp1,ovf | wr_en | wr_data | bicap | cnt | exp flags | exp cap0 | exp cap1}
    localparam int NV = 14;
    localparam logic [70:0] VEC [NV] = '{
        {5'b00001, 1'b0, 8'h00, 1'b0, 16'h1111, 8'h08, 16'h0000, 16'h0000},
        {5'b00100, 1'b0, 8'h00, 1'b0, 16'h1111, 8'h28, 16'h0000, 16'h0000},
        {5'b00100, 1'b0, 8'h00, 1'b0, 16'h1111, 8'h2A, 16'h0000, 16'h0000},
        {5'b00000, 1'b1, 8'h1F, 1'b0, 16'h1111, 8'h0B, 16'h0000, 16'h0000},
        {5'b01000, 1'b0, 8'h00, 1'b0, 16'h2222, 8'h4B, 16'h0000, 16'h2222},
        {5'b00000, 1'b1, 8'h00, 1'b0, 16'h2222, 8'h00, 16'h0000, 16'h2222},
        {5'b10000, 1'b0, 8'h00, 1'b0, 16'h3333, 8'h80, 16'h3333, 16'h2222},
        {5'b10000, 1'b0, 8'h00, 1'b0, 16'h4444, 8'h84, 16'h4444, 16'h2222},
        {5'b00000, 1'b1, 8'h80, 1'b0, 16'h5555, 8'h84, 16'h5555, 16'h2222},
        {5'b00000, 1'b1, 8'h00, 1'b0, 16'h5555, 8'h00, 16'h5555, 16'h2222},
        {5'b00000, 1'b1, 8'h40, 1'b1, 16'h7777, 8'h00, 16'h5555, 16'h2222},
        {5'b00000, 1'b1, 8'h40, 1'b0, 16'h6666, 8'h40, 16'h5555, 16'h6666},
        {5'b00001, 1'b1, 8'h00, 1'b0, 16'h6666, 8'h08, 16'h5555, 16'h6666},
        {5'b00010, 1'b0, 8'h00, 1'b0, 16'h6666, 8'h18, 16'h5555, 16'h6666}
    };

    function automatic string vreq(int i);
        case (i)
            0, 1, 4, 6, 13: return "R2";
            2, 7:           return "R7";
            3, 5, 9:        return "R3";
            8:              return "R5";
            10, 11:         return "R6";
            default:        return "R4";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic pulse(logic [4:0] ev, logic we, logic [7:0] wd, logic bic, logic [15:0] cnt);
        @(negedge clk);
        {ev_cap0, ev_cap1, ev_cmp0, ev_cmp1, ev_ovf} = ev;
        wr_en = we; wr_data = wd; bicap_mode = bic; cnt_val = cnt;
        @(negedge clk);
        {ev_cap0, ev_cap1, ev_cmp0, ev_cmp1, ev_ovf} = '0;
        wr_en = 0; wr_data = '0;
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #12 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "flags", 32'(flags_q), 32'h00);
        check("R1", "cap0", 32'(cap0_q), 32'h0);
        check("R1", "cap1", 32'(cap1_q), 32'h0);
        check("R1", "irqs", {29'b0, irq_cap, irq_cmp, irq_ovf}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][70:66], VEC[i][65], VEC[i][64:57], VEC[i][56], VEC[i][55:40]);
            check(vreq(i), $sformatf("vec%0d flags", i), 32'(flags_q), 32'(VEC[i][39:32]));
            check(vreq(i), $sformatf("vec%0d cap0", i), 32'(cap0_q), 32'(VEC[i][31:16]));
            check(vreq(i), $sformatf("vec%0d cap1", i), 32'(cap1_q), 32'(VEC[i][15:0]));
        end

        // R9: flags now 18h (compare-1 and overflow set)
        check("R9", "irqs with gie off", {29'b0, irq_cap, irq_cmp, irq_ovf}, 32'h0);
        gie = 1; ie_cmp1 = 1;
        @(negedge clk);
        check("R9", "irq_cmp via compare-1", 32'(irq_cmp), 32'h1);
        check("R9", "irq_ovf without enable", 32'(irq_ovf), 32'h0);
        ie_ovf = 1;
        @(negedge clk);
        check("R9", "irq_ovf enabled", 32'(irq_ovf), 32'h1);
        ie_cmp1 = 0; ie_cmp0 = 1;
        @(negedge clk);
        check("R9", "irq_cmp compare-0 clear", 32'(irq_cmp), 32'h0);

        // R8 capture combine
        ie_cap = 1;
        pulse(5'b00000, 1'b1, 8'h01, 1'b0, 16'h0);
        pulse(5'b10000, 1'b0, 8'h00, 1'b0, 16'h0ABC);
        check("R8", "irq_cap AND one flag", 32'(irq_cap), 32'h0);
        pulse(5'b01000, 1'b0, 8'h00, 1'b0, 16'h0DEF);
        @(negedge clk);
        check("R8", "irq_cap AND both flags", 32'(irq_cap), 32'h1);
        pulse(5'b00000, 1'b1, 8'h80, 1'b0, 16'h0123);
        check("R8", "flags after OR select", 32'(flags_q), 32'h84);
        @(negedge clk);
        check("R8", "irq_cap OR one flag", 32'(irq_cap), 32'h1);
        gie = 0;
        @(negedge clk);
        @(negedge clk);
        check("R9", "all irqs gie off", {29'b0, irq_cap, irq_cmp, irq_ovf}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule